// File: doc/BRIEF.md
# Dual-Port Memory with Flag-Space Decode

This block is a synchronous, true dual-port memory of 4096 bytes with two identical and independent ports, called left and right. Each port has an active-low memory select, an active-low flag-space select, an active-low output enable and a read/write strobe. The port decodes these four control bits into one of four outcomes: a memory access, a flag-space access, idle, or an illegal combination.

A flag-space access does not touch the memory array. It is forwarded on a side interface to an external unit that holds eight one-bit flags. That unit answers a read with its flag bit, and the port returns this bit spread across the whole read-data byte.

All read data is registered, with one clock of latency and a data-valid strobe for each port. The flag side interface is valid-only and has no back-pressure. The flag unit must take every request in the cycle it is presented, and it must drive the flag bit for a read in that same cycle. Same-address accesses from both ports follow fixed rules and are not arbitrated.

Top module: `dpram_semdec`

## Requirements
- R1: With memory select low (0) and flag select high (1), read/write high (1) reads and read/write low (0) writes the byte at the full 12-bit address. Read data and data-valid appear one clock after the request. Either port can read what either port wrote.
- R2: With memory select high and flag select low, the port raises its flag request in the same cycle, does not read or write the memory, sets the flag-write signal to the inverse of read/write, and forwards write-data bit 0 as the flag value.
- R3: With both selects high the port is idle. It raises no flag request, writes no memory, and shows data-valid low on the next clock.
- R4: With both selects low the port raises its error output on the next clock. It writes no memory, raises no flag request, and shows data-valid low.
- R5: With output enable high a read gives data-valid low and read data 0x00 on the next clock. Writes are unaffected by output enable.
- R6: The flag index is address bits 2:0. The upper nine address bits have no effect on a flag access.
- R7: A flag read with output enable low returns 0xFF when the flag bit is 1 and 0x00 when it is 0, with data-valid, one clock later.
- R8: The two ports act concurrently in the same cycle with no stall, and each port's result is unaffected by the other port's activity at a different address.
- R9: When both ports write the same address in the same cycle, the left port's data is stored.
- R10: A read on one port and a write on the other to the same address in the same cycle returns the old byte. A later read returns the new byte.
- R11: While reset is asserted and after it, before any request, data-valid and error are low and read data is 0x00 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left memory select, active low |
| l_sem_n | input | 1 | Left flag-space select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_addr | input | 12 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, 0x00 when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_err | output | 1 | Left illegal-select flag, one clock after the request |
| l_sem_valid | output | 1 | Left flag request |
| l_sem_write | output | 1 | Left flag request is a write |
| l_sem_idx | output | 3 | Left flag index |
| l_sem_wbit | output | 1 | Left flag write value |
| l_sem_flag | input | 1 | Left flag value returned for a read |
| r_cs_n | input | 1 | Right memory select, active low |
| r_sem_n | input | 1 | Right flag-space select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_addr | input | 12 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, 0x00 when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_err | output | 1 | Right illegal-select flag, one clock after the request |
| r_sem_valid | output | 1 | Right flag request |
| r_sem_write | output | 1 | Right flag request is a write |
| r_sem_idx | output | 3 | Right flag index |
| r_sem_wbit | output | 1 | Right flag write value |
| r_sem_flag | input | 1 | Right flag value returned for a read |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 8-bit data and a 3-bit flag index. This puts the lowest and highest memory addresses within reach. It also lets flag accesses use addresses whose upper bits are non-zero, which shows that only the low three bits reach the flag index. Building the full 4096-entry array makes the same-cycle collisions between the two ports observable: left-over-right on a double write, and old data on a read against a write. All sixteen control combinations are driven on one port while that port's memory contents are tracked.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;

  // Outcome of decoding one port's select pair.
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_MEM  = 2'd1,
    ACC_SEM  = 2'd2,
    ACC_BAD  = 2'd3
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic cs_n, input logic sem_n);
    unique case ({cs_n, sem_n})
      2'b01:   return ACC_MEM;
      2'b10:   return ACC_SEM;
      2'b11:   return ACC_IDLE;
      default: return ACC_BAD;
    endcase
  endfunction

endpackage

// File: rtl/port_decode.sv
module port_decode
  import dpsem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SEM_IDX_W = 3
) (
  input  logic                 cs_n,
  input  logic                 sem_n,
  input  logic                 oe_n,
  input  logic                 rw,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wbit0,
  output logic                 mem_we,
  output logic                 mem_re,
  output logic                 rd_req,
  output logic                 sem_sel,
  output logic                 sem_req,
  output logic                 sem_wr,
  output logic [SEM_IDX_W-1:0] sem_idx,
  output logic                 sem_wbit,
  output logic                 illegal
);

  acc_kind_e kind;
  logic      space_on;

  always_comb begin
    kind     = classify(cs_n, sem_n);
    space_on = (kind == ACC_MEM) || (kind == ACC_SEM);
    // A read is only carried out when the output is enabled.
    rd_req   = space_on && rw && !oe_n;
    mem_we   = (kind == ACC_MEM) && !rw;
    mem_re   = (kind == ACC_MEM) && rd_req;
    sem_sel  = (kind == ACC_SEM);
    sem_req  = sem_sel;
    sem_wr   = sem_sel && !rw;
    sem_idx  = addr[SEM_IDX_W-1:0];
    sem_wbit = wbit0;
    illegal  = (kind == ACC_BAD);
  end

endmodule

// File: rtl/dp_mem_core.sv
module dp_mem_core #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_l,
  input  logic              we_r,
  input  logic              re_l,
  input  logic              re_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wd_l,
  input  logic [DATA_W-1:0] wd_r,
  output logic [DATA_W-1:0] q_l,
  output logic [DATA_W-1:0] q_r
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Reads sample the array before this edge's writes land, so a
  // same-address read returns the old byte. The left write is issued
  // last, so it overrides the right one at a shared address.
  always_ff @(posedge clk) begin
    if (re_l) q_l <= mem[addr_l];
    if (re_r) q_r <= mem[addr_r];
    if (we_r) mem[addr_r] <= wd_r;
    if (we_l) mem[addr_l] <= wd_l;
  end

  assert_left_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_l && we_r && addr_l == addr_r) |=> (mem[$past(addr_l)] == $past(wd_l)));

  assert_right_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we_r && !(we_l && addr_l == addr_r)) |=> (mem[$past(addr_r)] == $past(wd_r)));

endmodule

// File: rtl/port_return.sv
module port_return #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              sem_sel,
  input  logic              flag_bit,
  input  logic              illegal,
  input  logic [DATA_W-1:0] core_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              err
);

  logic vld_q, from_sem_q, flag_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      from_sem_q <= 1'b0;
      flag_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      vld_q      <= rd_req;
      from_sem_q <= sem_sel;
      err_q      <= illegal;
      if (rd_req && sem_sel) flag_q <= flag_bit;
    end
  end

  always_comb begin
    if (!vld_q)          rdata = '0;
    else if (from_sem_q) rdata = {DATA_W{flag_q}};
    else                 rdata = core_q;
  end

  assign rvalid = vld_q;
  assign err    = err_q;

  assert_quiet_when_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));

  assert_flag_spread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && from_sem_q) |-> (rdata == '0 || rdata == '1));

endmodule

// File: rtl/dpram_semdec.sv
module dpram_semdec #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int SEM_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 l_cs_n,
  input  logic                 l_sem_n,
  input  logic                 l_oe_n,
  input  logic                 l_rw,
  input  logic [ADDR_W-1:0]    l_addr,
  input  logic [DATA_W-1:0]    l_wdata,
  output logic [DATA_W-1:0]    l_rdata,
  output logic                 l_rvalid,
  output logic                 l_err,
  output logic                 l_sem_valid,
  output logic                 l_sem_write,
  output logic [SEM_IDX_W-1:0] l_sem_idx,
  output logic                 l_sem_wbit,
  input  logic                 l_sem_flag,
  input  logic                 r_cs_n,
  input  logic                 r_sem_n,
  input  logic                 r_oe_n,
  input  logic                 r_rw,
  input  logic [ADDR_W-1:0]    r_addr,
  input  logic [DATA_W-1:0]    r_wdata,
  output logic [DATA_W-1:0]    r_rdata,
  output logic                 r_rvalid,
  output logic                 r_err,
  output logic                 r_sem_valid,
  output logic                 r_sem_write,
  output logic [SEM_IDX_W-1:0] r_sem_idx,
  output logic                 r_sem_wbit,
  input  logic                 r_sem_flag
);

  localparam int NPORT = 2;

  // Index 0 is the left port, index 1 the right port.
  logic [NPORT-1:0]    cs_n_a, sem_n_a, oe_n_a, rw_a, flag_a;
  logic [NPORT-1:0]    we_a, re_a, rdreq_a, semsel_a, semreq_a, semwr_a, wbit_a, bad_a;
  logic [NPORT-1:0]    rvalid_a, err_a;
  logic [ADDR_W-1:0]   addr_a  [NPORT];
  logic [DATA_W-1:0]   wdata_a [NPORT];
  logic [DATA_W-1:0]   q_a     [NPORT];
  logic [DATA_W-1:0]   rdata_a [NPORT];
  logic [SEM_IDX_W-1:0] idx_a  [NPORT];

  assign cs_n_a     = {r_cs_n,  l_cs_n};
  assign sem_n_a    = {r_sem_n, l_sem_n};
  assign oe_n_a     = {r_oe_n,  l_oe_n};
  assign rw_a       = {r_rw,    l_rw};
  assign flag_a     = {r_sem_flag, l_sem_flag};
  assign addr_a[0]  = l_addr;
  assign addr_a[1]  = r_addr;
  assign wdata_a[0] = l_wdata;
  assign wdata_a[1] = r_wdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    port_decode #(
      .ADDR_W   (ADDR_W),
      .SEM_IDX_W(SEM_IDX_W)
    ) i_dec (
      .cs_n    (cs_n_a[p]),
      .sem_n   (sem_n_a[p]),
      .oe_n    (oe_n_a[p]),
      .rw      (rw_a[p]),
      .addr    (addr_a[p]),
      .wbit0   (wdata_a[p][0]),
      .mem_we  (we_a[p]),
      .mem_re  (re_a[p]),
      .rd_req  (rdreq_a[p]),
      .sem_sel (semsel_a[p]),
      .sem_req (semreq_a[p]),
      .sem_wr  (semwr_a[p]),
      .sem_idx (idx_a[p]),
      .sem_wbit(wbit_a[p]),
      .illegal (bad_a[p])
    );

    port_return #(
      .DATA_W(DATA_W)
    ) i_ret (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_req  (rdreq_a[p]),
      .sem_sel (semsel_a[p]),
      .flag_bit(flag_a[p]),
      .illegal (bad_a[p]),
      .core_q  (q_a[p]),
      .rdata   (rdata_a[p]),
      .rvalid  (rvalid_a[p]),
      .err     (err_a[p])
    );

    assert_bad_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_a[p] && !sem_n_a[p]) |-> (!we_a[p] && !semreq_a[p]));

    assert_bad_raises_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_a[p] && !sem_n_a[p]) |=> (err_a[p] && !rvalid_a[p]));

    assert_flag_space_spares_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_a[p] && !sem_n_a[p]) |-> (!we_a[p] && !re_a[p] && semreq_a[p]));

    assert_idle_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_a[p] && sem_n_a[p]) |=> !rvalid_a[p]);

    assert_oe_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_a[p] |=> !rvalid_a[p]);

    assert_flag_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
      semreq_a[p] |-> (idx_a[p] == addr_a[p][SEM_IDX_W-1:0]));
  end

  dp_mem_core #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_core (
    .clk   (clk),
    .rst_n (rst_n),
    .we_l  (we_a[0]),
    .we_r  (we_a[1]),
    .re_l  (re_a[0]),
    .re_r  (re_a[1]),
    .addr_l(addr_a[0]),
    .addr_r(addr_a[1]),
    .wd_l  (wdata_a[0]),
    .wd_r  (wdata_a[1]),
    .q_l   (q_a[0]),
    .q_r   (q_a[1])
  );

  assign l_rdata     = rdata_a[0];
  assign l_rvalid    = rvalid_a[0];
  assign l_err       = err_a[0];
  assign l_sem_valid = semreq_a[0];
  assign l_sem_write = semwr_a[0];
  assign l_sem_idx   = idx_a[0];
  assign l_sem_wbit  = wbit_a[0];

  assign r_rdata     = rdata_a[1];
  assign r_rvalid    = rvalid_a[1];
  assign r_err       = err_a[1];
  assign r_sem_valid = semreq_a[1];
  assign r_sem_write = semwr_a[1];
  assign r_sem_idx   = idx_a[1];
  assign r_sem_wbit  = wbit_a[1];

endmodule

// File: tb/test_dpram_semdec.sv
module test_dpram_semdec;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        l_cs_n = 1, l_sem_n = 1, l_oe_n = 1, l_rw = 1, l_sem_flag = 0;
  logic [11:0] l_addr = '0;
  logic [7:0]  l_wdata = '0;
  logic [7:0]  l_rdata;
  logic        l_rvalid, l_err, l_sem_valid, l_sem_write, l_sem_wbit;
  logic [2:0]  l_sem_idx;
  logic        r_cs_n = 1, r_sem_n = 1, r_oe_n = 1, r_rw = 1, r_sem_flag = 0;
  logic [11:0] r_addr = '0;
  logic [7:0]  r_wdata = '0;
  logic [7:0]  r_rdata;
  logic        r_rvalid, r_err, r_sem_valid, r_sem_write, r_sem_wbit;
  logic [2:0]  r_sem_idx;

  dpram_semdec i_dpram_semdec (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_sem_n(l_sem_n), .l_oe_n(l_oe_n), .l_rw(l_rw),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .l_err(l_err), .l_sem_valid(l_sem_valid), .l_sem_write(l_sem_write),
    .l_sem_idx(l_sem_idx), .l_sem_wbit(l_sem_wbit), .l_sem_flag(l_sem_flag),
    .r_cs_n(r_cs_n), .r_sem_n(r_sem_n), .r_oe_n(r_oe_n), .r_rw(r_rw),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
    .r_err(r_err), .r_sem_valid(r_sem_valid), .r_sem_write(r_sem_write),
    .r_sem_idx(r_sem_idx), .r_sem_wbit(r_sem_wbit), .r_sem_flag(r_sem_flag)
  );

  // Control code {cs_n, sem_n, oe_n, rw}
  localparam logic [3:0] C_IDLE = 4'b1111, C_MRD = 4'b0101, C_MWR = 4'b0100,
                         C_SRD = 4'b1001, C_SWR = 4'b1000, C_BAD = 4'b0001,
                         C_MRD_OFF = 4'b0111;

  // {ctrl[3:0], exp_sem_req, exp_valid, exp_err, exp_mem_write}
  localparam logic [7:0] VEC [16] = '{
    8'h02, 8'h12, 8'h22, 8'h32,
    8'h41, 8'h54, 8'h61, 8'h70,
    8'h88, 8'h9C, 8'hA8, 8'hB8,
    8'hC0, 8'hD0, 8'hE0, 8'hF0
  };

  logic [7:0] ref_mem [4096];
  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_l(input logic [3:0] c, input logic [11:0] a, input logic [7:0] d);
    {l_cs_n, l_sem_n, l_oe_n, l_rw} = c; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(input logic [3:0] c, input logic [11:0] a, input logic [7:0] d);
    {r_cs_n, r_sem_n, r_oe_n, r_rw} = c; r_addr = a; r_wdata = d;
  endtask

  task automatic wr(input bit p, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    if (p) set_r(C_MWR, a, d); else set_l(C_MWR, a, d);
    @(negedge clk);
    if (p) set_r(C_IDLE, '0, '0); else set_l(C_IDLE, '0, '0);
    ref_mem[a] = d;
  endtask

  task automatic rd(input bit p, input logic [11:0] a, input string tag);
    @(negedge clk);
    if (p) set_r(C_MRD, a, '0); else set_l(C_MRD, a, '0);
    @(negedge clk);
    chk({tag, " valid"}, p ? r_rvalid : l_rvalid, 1);
    chk({tag, " data"}, p ? r_rdata : l_rdata, ref_mem[a]);
    if (p) set_r(C_IDLE, '0, '0); else set_l(C_IDLE, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 l_rvalid", l_rvalid, 0);
    chk("R11 r_rvalid", r_rvalid, 0);
    chk("R11 l_err", l_err, 0);
    chk("R11 r_rdata", r_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 l_rdata after release", l_rdata, 0);
    chk("R11 r_err after release", r_err, 0);

    // Table walk of all 16 control combinations on the left port (R1..R5, R7)
    for (int i = 0; i < 16; i++) begin
      logic [11:0] a;
      logic [3:0] c;
      logic e_sem, e_val, e_err, e_wr;
      a = 12'h100 + 12'(i);
      c = VEC[i][7:4];
      {e_sem, e_val, e_err, e_wr} = VEC[i][3:0];
      wr(0, a, 8'hC0 + 8'(i));
      @(negedge clk);
      set_l(c, a, 8'h31 + 8'(i));
      l_sem_flag = 1'b1;
      #1;
      chk($sformatf("R2 vec%0d sem_valid", i), l_sem_valid, e_sem);
      chk($sformatf("R2 vec%0d sem_write", i), l_sem_write, e_sem & ~c[0]);
      @(negedge clk);
      chk($sformatf("R4 vec%0d err", i), l_err, e_err);
      chk($sformatf("R5 vec%0d rvalid", i), l_rvalid, e_val);
      if (e_val) chk($sformatf("R1 vec%0d rdata", i), l_rdata, e_sem ? 8'hFF : ref_mem[a]);
      else       chk($sformatf("R5 vec%0d rdata idle", i), l_rdata, 8'h00);
      if (e_wr) ref_mem[a] = 8'h31 + 8'(i);
      set_l(C_IDLE, '0, '0);
      l_sem_flag = 1'b0;
      rd(0, a, $sformatf("R3 vec%0d memory after", i));
    end

    // R1 / R8: boundary addresses, cross-port readback
    wr(0, 12'h000, 8'h5A);
    wr(1, 12'hFFF, 8'hA5);
    rd(1, 12'h000, "R1 right reads left write at 0");
    rd(0, 12'hFFF, "R1 left reads right write at top");

    // R8: both ports active in one cycle at different addresses
    wr(1, 12'h222, 8'h77);
    @(negedge clk);
    set_l(C_MWR, 12'h333, 8'h99);
    set_r(C_MRD, 12'h222, '0);
    @(negedge clk);
    chk("R8 right read during left write valid", r_rvalid, 1);
    chk("R8 right read during left write data", r_rdata, 8'h77);
    ref_mem[12'h333] = 8'h99;
    set_l(C_IDLE, '0, '0); set_r(C_IDLE, '0, '0);
    rd(1, 12'h333, "R8 left write landed");

    // R9: double write to one address, left wins
    @(negedge clk);
    set_l(C_MWR, 12'h444, 8'h11);
    set_r(C_MWR, 12'h444, 8'h22);
    @(negedge clk);
    set_l(C_IDLE, '0, '0); set_r(C_IDLE, '0, '0);
    ref_mem[12'h444] = 8'h11;
    rd(1, 12'h444, "R9 left data kept");

    // R10: read against write, both directions
    wr(0, 12'h555, 8'h40);
    @(negedge clk);
    set_l(C_MRD, 12'h555, '0);
    set_r(C_MWR, 12'h555, 8'h41);
    @(negedge clk);
    chk("R10 left sees old byte", l_rdata, 8'h40);
    set_l(C_MWR, 12'h555, 8'h42);
    set_r(C_MRD, 12'h555, '0);
    @(negedge clk);
    chk("R10 right sees previous byte", r_rdata, 8'h41);
    set_l(C_IDLE, '0, '0); set_r(C_IDLE, '0, '0);
    ref_mem[12'h555] = 8'h42;
    rd(0, 12'h555, "R10 new byte later");

    // R6: flag index from low bits only, on the right port
    @(negedge clk);
    set_r(C_SWR, 12'hABD, 8'hFE);
    #1;
    chk("R6 index ignores upper bits", r_sem_idx, 3'd5);
    chk("R2 flag write value bit0", r_sem_wbit, 0);
    chk("R2 flag write strobe", r_sem_write, 1);
    set_r(C_SWR, 12'h002, 8'h01);
    #1;
    chk("R6 index low value", r_sem_idx, 3'd2);
    chk("R2 flag write value one", r_sem_wbit, 1);

    // R7: flag read spread, both values
    @(negedge clk);
    set_r(C_SRD, 12'hF03, '0); r_sem_flag = 1'b0;
    @(negedge clk);
    chk("R7 flag 0 valid", r_rvalid, 1);
    chk("R7 flag 0 reads 00", r_rdata, 8'h00);
    r_sem_flag = 1'b1;
    @(negedge clk);
    chk("R7 flag 1 reads FF", r_rdata, 8'hFF);
    set_r(C_IDLE, '0, '0);

    // R5: output disabled memory read on the right
    @(negedge clk);
    set_r(C_MRD_OFF, 12'h555, '0);
    @(negedge clk);
    chk("R5 oe high no valid", r_rvalid, 0);
    chk("R5 oe high data zero", r_rdata, 8'h00);
    set_r(C_IDLE, '0, '0);

    // R4: illegal write on the right leaves memory alone
    @(negedge clk);
    set_r(4'b0000, 12'h555, 8'hEE);
    #1;
    chk("R4 no flag request", r_sem_valid, 0);
    @(negedge clk);
    chk("R4 right err", r_err, 1);
    set_r(C_IDLE, '0, '0);
    @(negedge clk);
    chk("R4 err clears", r_err, 0);
    rd(0, 12'h555, "R4 memory untouched");

    // R3: idle cycle
    @(negedge clk);
    chk("R3 idle no request", l_sem_valid, 0);
    chk("R3 idle no valid", l_rvalid, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule